// File: doc/BRIEF.md
# Manchester II Serial Word Receiver for a 1553-Style Bus

This block turns the sampled logic-level receive line of one MIL-STD-1553 bus into 16-bit words. The line runs at one bit per 12 clock cycles, which is 1.0 us at a 12 MHz clock. A word opens with a sync pattern three bit times long. The receiver recognises the sync and tells whether it is the command/status form or the data form. It then decodes sixteen Manchester II data bits and one parity bit.

When a word is complete, the receiver loads its output register and raises a word-received flag. A separate fault flag reports a missing mid-bit transition, a parity mismatch or a broken sync. Both flags and the word hold their values until the next sync is recognised, so a host can pick up the result at any time before then.

The control is a four-state machine:
- `ST_HUNT` measures line runs. Its transition *sync_hit* leads to `ST_SYNC2`.
- `ST_SYNC2` checks the second half of the sync. Its transition *sync_bad* returns to `ST_HUNT`, and *sync_ok* moves on to `ST_DATA`.
- `ST_DATA` samples both halves of each bit slot. Its transition *last_slot* leads to `ST_DONE`.
- `ST_DONE` loads the results, then *reload* returns to `ST_HUNT`.

Top module: `m1553_word_rx`

## Requirements
- R1: Reset clears `rx_word` to 0 and drops `rx_valid` and `rx_err`.
- R2: A sync is recognised only when its first half, measured from the transition that starts it to the transition that ends it, lasts 16 to 20 clocks. A shorter or longer run is ignored and leaves every output unchanged. The line must therefore change level to begin a sync.
- R3: A sync whose first half is high is command/status and sets `rx_cmd_sync` to 1. A sync whose first half is low is data and sets it to 0.
- R4: Each data bit occupies 12 clocks after the 18-clock second sync half. A 1 is high then low, and a 0 is low then high. The first bit received lands in `rx_word[15]` and the sixteenth in `rx_word[0]`.
- R5: After the parity slot, `rx_word` and `rx_cmd_sync` are loaded and `rx_valid` goes to 1. All outputs then hold until the next recognised sync.
- R6: The parity bit makes the number of ones across the 16 data bits plus parity odd. A mismatch sets `rx_err` to 1 together with `rx_valid`.
- R7: A bit slot whose two half-samples are equal (no mid-bit transition) sets `rx_err` to 1 together with `rx_valid` at word end.
- R8: If the line leaves the second sync half level early, the word is discarded: `rx_err` is 1, `rx_valid` is 0 and `rx_word` keeps its previous value.
- R9: A recognised sync clears `rx_valid` and `rx_err`. They cannot rise again as a valid word sooner than 17 bit times later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock, 12 clocks per bit |
| rst | input | 1 | Synchronous reset, active high |
| rx_line | input | 1 | Logic-level receive line |
| rx_word | output | 16 | Last received word, first bit in MSB |
| rx_cmd_sync | output | 1 | 1 for command/status sync, 0 for data sync |
| rx_valid | output | 1 | Complete word received |
| rx_err | output | 1 | Encoding, parity or sync fault |

## Verification
The bench sends first sync halves of exactly 16 and 20 clocks, which must be taken, and of 15 and 21 clocks, which must leave the previous word and flags untouched. A run-length window off by one would either drop a legal word or start decoding on noise. A single flipped parity bit and a single slot with no mid-bit transition must each raise the fault flag while still reporting a finished word. A receiver that confused the two checks, or that counted even parity, would report a clean word instead. A sync whose second half collapses must raise only the fault flag and keep the old word. Flags observed mid-word must already be cleared, which catches a receiver that holds stale flags across a new sync.

// File: rtl/m1553_rx_pkg.sv
package m1553_rx_pkg;

    typedef enum logic [1:0] {
        ST_HUNT  = 2'd0,
        ST_SYNC2 = 2'd1,
        ST_DATA  = 2'd2,
        ST_DONE  = 2'd3
    } rx_state_t;

endpackage

// File: rtl/m1553_rx_front.sv
// Line synchroniser, transition detector and run-length counter.
module m1553_rx_front #(
    parameter int SYNC_STAGES = 2,
    parameter int RUN_MAX     = 21,
    parameter int RUN_W       = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             line_in,
    output logic             lvl,
    output logic             lvl_prev,
    output logic             edge_seen,
    output logic [RUN_W-1:0] run_len
);

    logic [SYNC_STAGES-1:0] sync_sh;

    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) sync_sh <= '0;
                else     sync_sh <= line_in;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) sync_sh <= '0;
                else     sync_sh <= {sync_sh[SYNC_STAGES-2:0], line_in};
            end
        end
    endgenerate

    assign lvl       = sync_sh[SYNC_STAGES-1];
    assign edge_seen = lvl ^ lvl_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_prev <= 1'b0;
            run_len  <= '0;
        end else begin
            lvl_prev <= lvl;
            if (edge_seen)
                run_len <= RUN_W'(1);
            else if (run_len != RUN_W'(RUN_MAX))
                run_len <= run_len + RUN_W'(1);
        end
    end

endmodule

// File: rtl/m1553_rx_fsm.sv
// Word framing state machine: sync check, bit sampling, parity.
module m1553_rx_fsm
    import m1553_rx_pkg::*;
#(
    parameter int BIT_CLKS  = 12,
    parameter int WORD_BITS = 16,
    parameter int HALF_MIN  = 16,
    parameter int HALF_MAX  = 20,
    parameter int RUN_W     = 5
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 lvl,
    input  logic                 lvl_prev,
    input  logic                 edge_seen,
    input  logic [RUN_W-1:0]     run_len,
    output logic [WORD_BITS-1:0] word_o,
    output logic                 cmd_o,
    output logic                 valid_o,
    output logic                 err_o
);

    localparam int HALF_CLKS = (BIT_CLKS * 3) / 2;
    localparam int NBITS     = WORD_BITS + 1;
    localparam int T_W       = $clog2(HALF_CLKS + 1);
    localparam int PH_W      = $clog2(BIT_CLKS);
    localparam int IDX_W     = $clog2(NBITS + 1);
    localparam int CHK_A     = HALF_CLKS / 2;
    localparam int CHK_B     = HALF_CLKS - 3;
    localparam int Q1        = BIT_CLKS / 4;
    localparam int Q3        = (BIT_CLKS * 3) / 4;

    rx_state_t state_q, state_d;

    logic [T_W-1:0]   tcnt;
    logic [PH_W-1:0]  ph;
    logic [IDX_W-1:0] bidx;
    logic [NBITS-1:0] shreg;
    logic             first_lvl;
    logic             half1;
    logic             manch_bad;

    logic sync_hit, sync_bad, sync_ok, last_slot, slot_end;

    assign sync_hit  = (state_q == ST_HUNT) && edge_seen &&
                       (run_len >= RUN_W'(HALF_MIN)) && (run_len <= RUN_W'(HALF_MAX));
    assign sync_bad  = (state_q == ST_SYNC2) && (lvl == first_lvl) &&
                       ((tcnt == T_W'(CHK_A)) || (tcnt == T_W'(CHK_B)));
    assign sync_ok   = (state_q == ST_SYNC2) && !sync_bad && (tcnt == T_W'(HALF_CLKS - 1));
    assign slot_end  = (ph == PH_W'(BIT_CLKS - 1));
    assign last_slot = (state_q == ST_DATA) && slot_end && (bidx == IDX_W'(NBITS - 1));

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_HUNT;
        else     state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HUNT:  if (sync_hit) state_d = ST_SYNC2;
            ST_SYNC2: begin
                if (sync_bad)     state_d = ST_HUNT;
                else if (sync_ok) state_d = ST_DATA;
            end
            ST_DATA:  if (last_slot) state_d = ST_DONE;
            ST_DONE:  state_d = ST_HUNT;
            default:  state_d = ST_HUNT;
        endcase
    end

    // Datapath and outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            tcnt      <= '0;
            ph        <= '0;
            bidx      <= '0;
            shreg     <= '0;
            first_lvl <= 1'b0;
            half1     <= 1'b0;
            manch_bad <= 1'b0;
            word_o    <= '0;
            cmd_o     <= 1'b0;
            valid_o   <= 1'b0;
            err_o     <= 1'b0;
        end else begin
            unique case (state_q)
                ST_HUNT: begin
                    if (sync_hit) begin
                        first_lvl <= lvl_prev;
                        tcnt      <= T_W'(1);
                        ph        <= '0;
                        bidx      <= '0;
                        manch_bad <= 1'b0;
                        valid_o   <= 1'b0;
                        err_o     <= 1'b0;
                    end
                end
                ST_SYNC2: begin
                    tcnt <= tcnt + T_W'(1);
                    if (sync_bad) err_o <= 1'b1;
                end
                ST_DATA: begin
                    if (ph == PH_W'(Q1)) half1 <= lvl;
                    if ((ph == PH_W'(Q3)) && (lvl == half1)) manch_bad <= 1'b1;
                    if (slot_end) begin
                        shreg <= {shreg[NBITS-2:0], half1};
                        ph    <= '0;
                        bidx  <= bidx + IDX_W'(1);
                    end else begin
                        ph <= ph + PH_W'(1);
                    end
                end
                ST_DONE: begin
                    word_o  <= shreg[NBITS-1:1];
                    cmd_o   <= first_lvl;
                    valid_o <= 1'b1;
                    err_o   <= manch_bad | ~(^shreg);
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/m1553_word_rx.sv
module m1553_word_rx #(
    parameter int BIT_CLKS    = 12,
    parameter int WORD_BITS   = 16,
    parameter int HALF_MIN    = 16,
    parameter int HALF_MAX    = 20,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 rx_line,
    output logic [WORD_BITS-1:0] rx_word,
    output logic                 rx_cmd_sync,
    output logic                 rx_valid,
    output logic                 rx_err
);

    localparam int RUN_MAX = HALF_MAX + 1;
    localparam int RUN_W   = $clog2(RUN_MAX + 1);

    logic             lvl, lvl_prev, edge_seen;
    logic [RUN_W-1:0] run_len;

    m1553_rx_front #(
        .SYNC_STAGES(SYNC_STAGES),
        .RUN_MAX    (RUN_MAX),
        .RUN_W      (RUN_W)
    ) u_front (
        .clk      (clk),
        .rst      (rst),
        .line_in  (rx_line),
        .lvl      (lvl),
        .lvl_prev (lvl_prev),
        .edge_seen(edge_seen),
        .run_len  (run_len)
    );

    m1553_rx_fsm #(
        .BIT_CLKS (BIT_CLKS),
        .WORD_BITS(WORD_BITS),
        .HALF_MIN (HALF_MIN),
        .HALF_MAX (HALF_MAX),
        .RUN_W    (RUN_W)
    ) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .lvl      (lvl),
        .lvl_prev (lvl_prev),
        .edge_seen(edge_seen),
        .run_len  (run_len),
        .word_o   (rx_word),
        .cmd_o    (rx_cmd_sync),
        .valid_o  (rx_valid),
        .err_o    (rx_err)
    );

endmodule

// File: rtl/m1553_rx_chk.sv
module m1553_rx_chk #(
    parameter int BIT_CLKS  = 12,
    parameter int WORD_BITS = 16
) (
    input logic                 clk,
    input logic                 rst,
    input logic [WORD_BITS-1:0] rx_word,
    input logic                 rx_cmd_sync,
    input logic                 rx_valid,
    input logic                 rx_err
);

    localparam int MIN_GAP = (WORD_BITS + 1) * BIT_CLKS;
    localparam int GAP_W   = $clog2(MIN_GAP + 1);

    logic [GAP_W-1:0] quiet_cnt;

    always_ff @(posedge clk) begin
        if (rst)
            quiet_cnt <= '0;
        else if (rx_valid || rx_err)
            quiet_cnt <= '0;
        else if (quiet_cnt != GAP_W'(MIN_GAP))
            quiet_cnt <= quiet_cnt + GAP_W'(1);
    end

    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (rx_word == '0) && !rx_valid && !rx_err);

    assert_hold_while_valid_R5: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && $past(rx_valid)) |-> ($stable(rx_word) && $stable(rx_cmd_sync)));

    assert_flags_from_clear_R9: assert property (@(posedge clk) disable iff (rst)
        ($rose(rx_valid) || $rose(rx_err)) |-> $past(!rx_valid && !rx_err));

    assert_word_gap_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_valid) |-> (quiet_cnt >= GAP_W'(MIN_GAP - 1)));

    assert_flags_drop_together_R9: assert property (@(posedge clk) disable iff (rst)
        $fell(rx_valid) |-> !rx_err);

endmodule

bind m1553_word_rx m1553_rx_chk #(
    .BIT_CLKS (BIT_CLKS),
    .WORD_BITS(WORD_BITS)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .rx_word    (rx_word),
    .rx_cmd_sync(rx_cmd_sync),
    .rx_valid   (rx_valid),
    .rx_err     (rx_err)
);

// File: tb/sim_m1553_word_rx.sv
module sim_m1553_word_rx;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rx_line = 1'b0;
    logic [15:0] rx_word;
    logic        rx_cmd_sync, rx_valid, rx_err;

    always #10 clk = ~clk;

    m1553_word_rx u0 (
        .clk        (clk),
        .rst        (rst),
        .rx_line    (rx_line),
        .rx_word    (rx_word),
        .rx_cmd_sync(rx_cmd_sync),
        .rx_valid   (rx_valid),
        .rx_err     (rx_err)
    );

    typedef struct {
        logic [15:0] w;
        logic        cmd;
        logic        v;
        logic        e;
        bit          chk_w;
        string       tag;
    } exp_t;

    exp_t q[$];
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   done_q = 1'b0;
    bit   ended = 1'b0;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_up();
        if (!ended) begin
            ended = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // Monitor: compare each completed result against the scoreboard
    always @(negedge clk) begin
        bit done;
        done = !rst && (rx_valid || rx_err);
        if (done && !done_q) begin
            if (q.size() == 0) begin
                check("unexpected result", 32'(rx_valid), 32'h0);
            end else begin
                exp_t x;
                x = q.pop_front();
                check({x.tag, " valid"}, 32'(rx_valid), 32'(x.v));
                check({x.tag, " err"},   32'(rx_err),   32'(x.e));
                if (x.chk_w) begin
                    check({x.tag, " word"}, 32'(rx_word),     32'(x.w));
                    check({x.tag, " sync"}, 32'(rx_cmd_sync), 32'(x.cmd));
                end
            end
        end
        done_q = done;
    end

    task automatic drive(input logic lvl, input int n);
        rx_line = lvl;
        repeat (n) @(negedge clk);
    endtask

    task automatic manch(input logic b);
        if (b) begin drive(1'b1, 6); drive(1'b0, 6); end
        else   begin drive(1'b0, 6); drive(1'b1, 6); end
    endtask

    // Driver: push the expected item, then emit the word on the line
    task automatic send(input logic cmd, input logic [15:0] d, input int fh,
                        input int bad_bit, input bit flip_par, input bit sync_fail,
                        input string tag);
        exp_t x;
        logic par;
        par     = ~(^d) ^ flip_par;
        x.w     = d;
        x.cmd   = cmd;
        x.v     = !sync_fail;
        x.e     = sync_fail || flip_par || (bad_bit >= 0);
        x.chk_w = !sync_fail && (bad_bit < 0);
        x.tag   = tag;
        q.push_back(x);
        drive(~cmd, 30);
        drive(cmd, fh);
        if (sync_fail) begin
            drive(~cmd, 5);
            drive(cmd, 30);
        end else begin
            drive(~cmd, 18);
            for (int i = 0; i < 17; i++) begin
                logic b;
                b = (i < 16) ? d[15-i] : par;
                if (i == bad_bit) drive(b, 12);
                else              manch(b);
            end
            drive(~cmd, 30);
        end
    endtask

    task automatic reject(input int len);
        drive(1'b0, 30);
        drive(1'b1, len);
        drive(1'b0, 40);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        finish_up();
    end

    initial begin
        repeat (4) @(negedge clk);
        check("R1 reset word",  32'(rx_word),  32'h0);
        check("R1 reset valid", 32'(rx_valid), 32'h0);
        check("R1 reset err",   32'(rx_err),   32'h0);
        rst = 1'b0;
        repeat (4) @(negedge clk);

        send(1'b1, 16'hA5C3, 18, -1, 1'b0, 1'b0, "R3 R4 R5 cmd word");
        send(1'b0, 16'h1234, 18, -1, 1'b0, 1'b0, "R3 data word");
        send(1'b1, 16'hFFFF, 18, -1, 1'b0, 1'b0, "R4 all ones");
        send(1'b0, 16'h8001, 18, -1, 1'b0, 1'b0, "R4 bit order");
        send(1'b1, 16'h0F0F, 16, -1, 1'b0, 1'b0, "R2 half 16");
        send(1'b1, 16'hF0F0, 20, -1, 1'b0, 1'b0, "R2 half 20");

        reject(15);
        check("R2 short run valid", 32'(rx_valid), 32'h1);
        check("R2 short run word",  32'(rx_word),  32'hF0F0);
        reject(21);
        check("R2 long run valid",  32'(rx_valid), 32'h1);
        check("R2 long run word",   32'(rx_word),  32'hF0F0);

        send(1'b0, 16'h5555, 18, -1, 1'b1, 1'b0, "R6 parity flip");
        send(1'b1, 16'h3C3C, 18, 5, 1'b0, 1'b0, "R7 no mid transition");

        send(1'b0, 16'h0000, 18, -1, 1'b0, 1'b0, "R6 zero word");
        send(1'b1, 16'hDEAD, 18, -1, 1'b0, 1'b1, "R8 broken sync");
        check("R8 word kept", 32'(rx_word), 32'h0000);

        fork
            send(1'b0, 16'h7E81, 18, -1, 1'b0, 1'b0, "R9 after error");
            begin
                repeat (150) @(negedge clk);
                check("R9 valid cleared", 32'(rx_valid), 32'h0);
                check("R9 err cleared",   32'(rx_err),   32'h0);
            end
        join

        repeat (10) @(negedge clk);
        check("R5 scoreboard drained", 32'(q.size()), 32'h0);
        check("R5 word held", 32'(rx_word), 32'h7E81);

        rst = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 midrun reset word",  32'(rx_word),  32'h0);
        check("R1 midrun reset valid", 32'(rx_valid), 32'h0);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        finish_up();
    end

endmodule